// File: doc/BRIEF.md
# Multi-Cause Reset Sequencer

This block merges four independent reset causes into a single core reset for a processor subsystem: a power-on detect, an active-low external reset pin, a watchdog timeout, and a clock-failure flag. The core reset goes low as soon as any cause is present, whether or not a clock is running. It is released only after every cause has gone away and the system clock has produced a fixed number of edges. The release path runs through a short synchroniser and then a counter.

When the core reset is released, the block also reports the low byte of the reset vector the processor must fetch. Power-on and the external pin share the normal vector. The clock-failure cause and the watchdog cause each have their own vector. If several causes fall into one reset episode, the one with the highest priority picks the vector.

A separate sticky cause register records every cause seen since the last power-on, so software can inspect it after release. A new power-on reset is the only thing that clears it.

Top module: `rstseq_top`

## Requirements
- R1: While any cause is active (power-on request high, external pin low, watchdog timeout high, or clock failure high), `core_rst_n_o` is low, and it goes low without needing any clock edge.
- R2: The external pin is active-low: `ext_rst_n_i` = 0 is a reset cause and `ext_rst_n_i` = 1 is not.
- R3: `core_rst_n_o` rises on exactly the (SYNC_STAGES + RELEASE_CYCLES)-th rising clock edge after the last cause went inactive, which is edge 18 with the defaults 2 and 16.
- R4: While no clock edges occur, `core_rst_n_o` stays low, even after all causes have gone away.
- R5: A cause that appears during the release countdown restarts the countdown from zero.
- R6: An episode that contains power-on or the external pin releases with `vec_lo_o` = 0xFE.
- R7: An episode whose highest cause is clock failure releases with `vec_lo_o` = 0xFC.
- R8: An episode that contains only the watchdog cause releases with `vec_lo_o` = 0xFA.
- R9: Causes in one episode are ranked power-on/external first, then clock failure, then watchdog.
- R10: After release, `vec_lo_o` holds its value until the next release.
- R11: `cause_o` bit 0 is power-on, bit 1 is the external pin, bit 2 is clock failure and bit 3 is watchdog. Each bit is set when its cause appears. A bit is cleared only at a clock edge at which power-on is high and its own cause is inactive.
- R12: The causes that choose the vector are forgotten at each release, so a later episode is ranked only on its own causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that sequences the release |
| por_req_i | input | 1 | Power-on detect, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| cop_tmo_i | input | 1 | Watchdog timeout, active high |
| cmon_fail_i | input | 1 | Clock-failure flag, active high |
| core_rst_n_o | output | 1 | Core reset, active low, asserted asynchronously and released on a clock edge |
| vec_lo_o | output | 8 | Low byte of the reset vector for the last released episode |
| cause_o | output | 4 | Sticky record of the causes seen since power-on |

## Verification
The release edge and the arrival of a new cause can fall in the same cycle. A cause that shows up partway through the countdown must restart it, and the vector latched on that edge must rank every cause of the episode.

The bench provokes this in three ways. It raises a second cause a few cycles before the countdown would end. It drops one cause on the same edge at which another is still held. It asserts the watchdog cause while the clock is stopped.

A behavioural edge counter and per-episode cause set in the bench predict the release cycle and the expected vector. The outputs are compared on every falling edge, and also immediately after each change made while the clock is stopped.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Index of each reset cause inside the cause vectors.
    localparam int NUM_SRC  = 4;
    localparam int SRC_POR  = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_CMON = 2;
    localparam int SRC_COP  = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Priority pick of a vector byte from the causes of one episode.
    function automatic logic [7:0] pick_vector(
        input src_vec_t   ep,
        input logic [7:0] v_norm,
        input logic [7:0] v_cmon,
        input logic [7:0] v_cop
    );
        if (ep[SRC_POR] || ep[SRC_EXT]) return v_norm;
        else if (ep[SRC_CMON])          return v_cmon;
        else if (ep[SRC_COP])           return v_cop;
        else                            return v_norm;
    endfunction

endpackage

// File: rtl/rstseq_flags.sv
// Bank of set-dominant cause flags.
// Each bit is set asynchronously on the rising edge of its own set input,
// and it stays set on every clock edge while that input is high. It is
// cleared on a clock edge where its clear input is high and its set input
// is low. Assumes set inputs are glitch-free level signals.
module rstseq_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic set_b;
        logic clr_b;
        logic bit_q;

        assign set_b = set_i[i];
        assign clr_b = clr_i[i];

        // Purpose: capture the cause without a clock, forget it on request.
        always_ff @(posedge clk or posedge set_b) begin
            if (set_b)      bit_q <= 1'b1;
            else if (clr_b) bit_q <= 1'b0;
        end

        assign q_o[i] = bit_q;
    end

endmodule

// File: rtl/rstseq_release.sv
// Release sequencer.
// A hold request clears every register at once, with no clock needed.
// After the hold ends, a SYNC_STAGES-deep chain brings the quiet state
// into the clock domain. A counter then waits RELEASE_CYCLES more edges
// before it lets the reset go.
// Assumes SYNC_STAGES >= 2 and RELEASE_CYCLES >= 1.
module rstseq_release #(
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_CYCLES = 16
) (
    input  logic clk,
    input  logic hold_i,
    output logic rel_n_o,
    output logic rel_pulse_o
);

    localparam int CW = $clog2(RELEASE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   rel_q;
    logic                   quiet;

    assign quiet = sync_q[SYNC_STAGES-1];

    // Purpose: synchronise the end of the hold into the clock domain.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end

    // Purpose: count quiet edges until the release point.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i)              cnt_q <= '0;
        else if (quiet && !rel_q) cnt_q <= cnt_q + 1'b1;
    end

    assign rel_pulse_o = quiet && !rel_q && (cnt_q == LAST);

    // Purpose: the released flag itself, set once and cleared only by hold.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i)           rel_q <= 1'b0;
        else if (rel_pulse_o) rel_q <= 1'b1;
    end

    assign rel_n_o = rel_q;

endmodule

// File: rtl/rstseq_vecsel.sv
// Vector selector.
// While the core is held in reset, it tracks the priority choice among the
// causes of the current episode on every clock edge. Once released, it
// freezes, so the value seen at release stays until the next release.
module rstseq_vecsel
    import rstseq_pkg::*;
#(
    parameter logic [7:0] VEC_NORMAL = 8'hFE,
    parameter logic [7:0] VEC_CMON   = 8'hFC,
    parameter logic [7:0] VEC_COP    = 8'hFA
) (
    input  logic       clk,
    input  logic       in_reset_i,
    input  src_vec_t   episode_i,
    output logic [7:0] vec_o
);

    logic [7:0] vec_q;

    // Purpose: follow the episode's winner while in reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (in_reset_i) vec_q <= pick_vector(episode_i, VEC_NORMAL, VEC_CMON, VEC_COP);
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/rstseq_top.sv
// Multi-cause reset sequencer, top level.
// It merges four reset causes into an active-low core reset. The reset is
// asserted with no clock and released on the system clock once every cause
// has been quiet long enough. It also reports the vector byte of the
// released episode and a sticky record of causes that only power-on clears.
// Assumes the cause inputs are free of glitches.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int         SYNC_STAGES    = 2,
    parameter int         RELEASE_CYCLES = 16,
    parameter logic [7:0] VEC_NORMAL     = 8'hFE,
    parameter logic [7:0] VEC_CMON       = 8'hFC,
    parameter logic [7:0] VEC_COP        = 8'hFA
) (
    input  logic       clk,
    input  logic       por_req_i,
    input  logic       ext_rst_n_i,
    input  logic       cop_tmo_i,
    input  logic       cmon_fail_i,
    output logic       core_rst_n_o,
    output logic [7:0] vec_lo_o,
    output logic [3:0] cause_o
);

    src_vec_t src_vec;
    src_vec_t episode;
    src_vec_t sticky;
    logic     any_src;
    logic     rel_n;
    logic     rel_pulse;

    // Active-high view of every cause, in package index order.
    assign src_vec[SRC_POR]  = por_req_i;
    assign src_vec[SRC_EXT]  = ~ext_rst_n_i;
    assign src_vec[SRC_CMON] = cmon_fail_i;
    assign src_vec[SRC_COP]  = cop_tmo_i;
    assign any_src           = |src_vec;

    rstseq_release #(
        .SYNC_STAGES   (SYNC_STAGES),
        .RELEASE_CYCLES(RELEASE_CYCLES)
    ) u_release (
        .clk        (clk),
        .hold_i     (any_src),
        .rel_n_o    (rel_n),
        .rel_pulse_o(rel_pulse)
    );

    // Causes of the current episode, forgotten on the release edge.
    rstseq_flags #(.WIDTH(NUM_SRC)) u_episode (
        .clk  (clk),
        .set_i(src_vec),
        .clr_i({NUM_SRC{rel_pulse}}),
        .q_o  (episode)
    );

    // Sticky record, cleared only while power-on is high.
    rstseq_flags #(.WIDTH(NUM_SRC)) u_sticky (
        .clk  (clk),
        .set_i(src_vec),
        .clr_i({NUM_SRC{por_req_i}}),
        .q_o  (sticky)
    );

    rstseq_vecsel #(
        .VEC_NORMAL(VEC_NORMAL),
        .VEC_CMON  (VEC_CMON),
        .VEC_COP   (VEC_COP)
    ) u_vecsel (
        .clk       (clk),
        .in_reset_i(~rel_n),
        .episode_i (episode),
        .vec_o     (vec_lo_o)
    );

    assign core_rst_n_o = rel_n;
    assign cause_o      = sticky;

endmodule

// File: rtl/rstseq_checker.sv
// Property checker for rstseq_top, attached through bind.
// It keeps its own count of quiet edges so that the release window can be
// checked without a deep $past.
module rstseq_checker #(
    parameter int         SYNC_STAGES    = 2,
    parameter int         RELEASE_CYCLES = 16,
    parameter logic [7:0] VEC_NORMAL     = 8'hFE,
    parameter logic [7:0] VEC_CMON       = 8'hFC,
    parameter logic [7:0] VEC_COP        = 8'hFA
) (
    input logic       clk,
    input logic       por_i,
    input logic [3:0] src_i,
    input logic       core_rst_n,
    input logic [7:0] vec,
    input logic [3:0] cause
);

    localparam int WIN = SYNC_STAGES + RELEASE_CYCLES;
    localparam int QW  = $clog2(WIN + 2);

    logic          any_s;
    logic [QW-1:0] quiet_q;

    assign any_s = |src_i;

    // Purpose: saturating count of clock edges with every cause quiet.
    always_ff @(posedge clk or posedge any_s) begin
        if (any_s)                       quiet_q <= '0;
        else if (quiet_q < QW'(WIN + 1)) quiet_q <= quiet_q + 1'b1;
    end

    p_async_hold_r1: assert property (@(posedge clk) disable iff (por_i)
        any_s |-> !core_rst_n);

    p_no_early_release_r3: assert property (@(posedge clk) disable iff (por_i)
        core_rst_n |-> (quiet_q >= QW'(WIN)));

    p_no_late_release_r3: assert property (@(posedge clk) disable iff (por_i)
        (quiet_q >= QW'(WIN + 1)) |-> core_rst_n);

    p_vec_legal_r6: assert property (@(posedge clk) disable iff (por_i)
        core_rst_n |-> (vec == VEC_NORMAL || vec == VEC_CMON || vec == VEC_COP));

    p_vec_hold_r10: assert property (@(posedge clk) disable iff (por_i)
        (core_rst_n && $past(core_rst_n)) |-> $stable(vec));

    p_cause_sticky_r11: assert property (@(posedge clk) disable iff (por_i)
        !$past(por_i) |-> ((cause & $past(cause)) == $past(cause)));

    p_cause_tracks_r11: assert property (@(posedge clk) disable iff (por_i)
        (src_i & ~cause) == 4'b0000);

endmodule

bind rstseq_top rstseq_checker #(
    .SYNC_STAGES   (SYNC_STAGES),
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .VEC_NORMAL    (VEC_NORMAL),
    .VEC_CMON      (VEC_CMON),
    .VEC_COP       (VEC_COP)
) chk_i (
    .clk       (clk),
    .por_i     (por_req_i),
    .src_i     ({cop_tmo_i, cmon_fail_i, ~ext_rst_n_i, por_req_i}),
    .core_rst_n(core_rst_n_o),
    .vec       (vec_lo_o),
    .cause     (cause_o)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;

    localparam int S = 2;
    localparam int N = 16;
    localparam int WIN = S + N;

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic por = 1'b1, ext_n = 1'b1, cop = 1'b0, cmon = 1'b0;
    logic       core_rst_n;
    logic [7:0] vec;
    logic [3:0] cause;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Reference model state
    int       k = 0;
    bit [3:0] ep = '0;
    bit [3:0] m_cause = '0;
    bit [7:0] ev = 8'h00;
    bit       rel_seen = 1'b0;
    bit       started = 1'b0;

    always #5 clk = clk_en ? ~clk : clk;

    rstseq_top #(.SYNC_STAGES(S), .RELEASE_CYCLES(N)) dut_i (
        .clk         (clk),
        .por_req_i   (por),
        .ext_rst_n_i (ext_n),
        .cop_tmo_i   (cop),
        .cmon_fail_i (cmon),
        .core_rst_n_o(core_rst_n),
        .vec_lo_o    (vec),
        .cause_o     (cause)
    );

    function automatic bit [3:0] srcs();
        return {cop, cmon, ~ext_n, por};
    endfunction

    // R9 ranking: power-on/external, then clock failure, then watchdog.
    function automatic bit [7:0] rank(input bit [3:0] e);
        if (e[0] || e[1]) return 8'hFE;
        if (e[2])         return 8'hFC;
        if (e[3])         return 8'hFA;
        return 8'hFE;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Immediate model response to a cause appearing (asynchronous set).
    task automatic apply_async();
        bit [3:0] s = srcs();
        ep      |= s;
        m_cause |= s;
        if (|s) k = 0;
    endtask

    task automatic drive(input logic p, input logic en, input logic c, input logic m);
        @(posedge clk);
        #2;
        por = p; ext_n = en; cop = c; cmon = m;
        apply_async();
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        bit [3:0] s;
        s = srcs();
        cyc++;
        started = 1'b1;
        ep |= s;
        if (|s) k = 0;
        else if (k < 1000) k++;
        if (!(|s) && k == WIN) begin
            ev = rank(ep);
            ep = '0;
            rel_seen = 1'b1;
        end
        if (por) m_cause = s;
        else     m_cause |= s;
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        bit exp_rst;
        if (started) begin
            exp_rst = !(|srcs()) && (k >= WIN);
            chk("core_rst_n", int'(core_rst_n), int'(exp_rst));
            chk("cause", int'(cause), int'(m_cause));
            if (exp_rst && rel_seen) chk("vec", int'(vec), int'(ev));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 / R11: power-on holds the core in reset and leaves only bit 0 in the record.
        cur_req = "R1";
        idle(5);
        cur_req = "R6";
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R2: external pin low is a cause; R6 normal vector.
        cur_req = "R2";
        drive(0, 0, 0, 0);
        idle(3);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R7: clock failure alone.
        cur_req = "R7";
        drive(0, 1, 0, 1);
        idle(2);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R8 / R12: watchdog alone after earlier normal episodes.
        cur_req = "R8";
        drive(0, 1, 1, 0);
        idle(2);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R5 / R9: second cause late in the countdown restarts it and outranks.
        cur_req = "R5";
        drive(0, 1, 1, 0);
        drive(0, 1, 0, 0);
        idle(WIN - 4);
        drive(0, 1, 0, 1);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R9 / R11: power-on together with watchdog clears old record bits.
        cur_req = "R9";
        drive(1, 1, 1, 0);
        idle(3);
        drive(0, 1, 1, 0);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R9: external plus clock failure, dropped on different edges.
        cur_req = "R9";
        drive(0, 0, 0, 1);
        drive(0, 1, 0, 1);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R3: single-cycle watchdog pulse, exact release edge checked each cycle.
        cur_req = "R3";
        drive(0, 1, 1, 0);
        drive(0, 1, 0, 0);
        idle(WIN + 4);

        // R4 / R1: cause while the clock is stopped.
        cur_req = "R4";
        @(negedge clk);
        clk_en = 1'b0;
        #20;
        cop = 1'b1;
        apply_async();
        #1;
        chk("core_rst_n no clock (R1)", int'(core_rst_n), 0);
        #50;
        cop = 1'b0;
        #200;
        chk("core_rst_n held without clock (R4)", int'(core_rst_n), 0);
        clk_en = 1'b1;
        cur_req = "R10";
        idle(WIN + 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule